// File: doc/BRIEF.md
# Word-Wide EPROM Read Port

This block is a clocked, synthesizable stand-in for the device side of a one-time-programmable memory's read interface. The memory is organised as 2M words of 16 bits. A host presents a 21-bit word address, an active-low chip select (`ce_n`), an active-low output gate (`oe_n`) and a flag (`a9_hv`) that means a high voltage is on address line 9. The block answers on a 16-bit data bus. A separate `dq_oe` signal takes the place of a tri-state driver, and the bus reads zero whenever `dq_oe` is low.

The three access delays of a real part are given as clock-cycle counts. The first runs from the moment the address settles. The second runs from the moment chip select goes low. The third runs from the moment the output gate goes low. The bus is driven only when all three have run out. While the bus is driven, an address change keeps the old word on the bus until the address delay has passed again. The storage is a small parameterised register array that reads all ones after reset. A test port loads it.

The test port is a single write strobe with no ready signal. It accepts one word on every cycle in which it is raised, so it never applies back-pressure. With the flag raised and every address line other than 0 and 9 low, the block returns a fixed identification word. If the flag is raised while a stray address line is high, the block reads the array as normal and raises a sticky error flag.

Top module: `wrp_read_port`

## Requirements
- R1: After reset, `dq_oe` and `id_err` are low, `dq` is zero, and every array word reads 16'hFFFF.
- R2: A rising edge that samples `ce_n` high leaves `dq_oe` low after it. Whenever `dq_oe` is low, `dq` is 16'h0000.
- R3: A rising edge that samples `ce_n` low and `oe_n` high leaves `dq_oe` low after it.
- R4: `dq_oe` first goes high after an edge at which three conditions all hold. `ce_n` was sampled low at that edge and at the T_CE edges before it. `oe_n` was sampled low at that edge and at the T_OE edges before it. `{a9_hv, addr}` was sampled unchanged at that edge and at the T_ADDR edges before it. With the defaults, T_ADDR is 10, T_CE is 10 and T_OE is 5.
- R5: The bus is released at the first rising edge that samples either `ce_n` or `oe_n` high. There is no added delay.
- R6: While the bus is driven, a change of `{a9_hv, addr}` keeps `dq_oe` high and `dq` at the old word. The new word appears after the edge at which the new address meets the settling rule of R4.
- R7: In normal mode (`a9_hv` low), the word read is array entry `addr[IDX_W-1:0]`. The higher address bits do not select a word, so they alias.
- R8: An edge with `pre_we` high writes `pre_data` into entry `pre_addr`. Later reads of that entry return the new word.
- R9: Identification mode applies when `a9_hv` is high and every address bit except bits 0 and 9 is low. In this mode `dq` is 16'h0020 when `addr[0]` is 0 and 16'h0034 when `addr[0]` is 1. Bits 15 to 8 are zero, and `addr[9]` is ignored.
- R10: When `a9_hv` is high while any address bit other than 0 and 9 is high, the array is read as in R7. `id_err` goes high at that edge and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 21 | Word address |
| ce_n | input | 1 | Active-low chip select; high means standby |
| oe_n | input | 1 | Active-low output gate |
| a9_hv | input | 1 | High voltage present on address line 9 |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | IDX_W | Preload entry index |
| pre_data | input | 16 | Preload word |
| dq | output | 16 | Read data, zero when not driven |
| dq_oe | output | 1 | Bus driven |
| id_err | output | 1 | Sticky flag: identification requested with a stray address line high |

## Verification
The bench measures each access delay to the exact edge on its own. It checks one cycle early and then on the edge itself, so an off-by-one counter, or a design that skips one of the three conditions, drives the bus too early or too late. It changes the address while the bus is driven with two different array words in play. A design that does not hold would show a blank bus or the new word too soon. The identification checks include `addr[9]` set and stray higher bits. A decoder that looks at the wrong bits would return the codes from the array space, or would fail to raise and keep the sticky flag.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;
  localparam int HV_BIT = 9;
  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = 8'h34;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] waddr_t;
endpackage

// File: rtl/wrp_settle_timer.sv
module wrp_settle_timer #(
  parameter int unsigned LIM = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic kick,
  output logic ok
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] TOP = CW'(LIM);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      cnt_q <= '0;
    end else if (kick) begin
      cnt_q <= CW'(1);
    end else if (cnt_q != TOP) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign ok = arm && !kick && (cnt_q == TOP);
endmodule

// File: rtl/wrp_store.sv
module wrp_store #(
  parameter int IDX_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          waddr,
  input  wrp_pkg::word_t            wdata,
  input  logic [IDX_W-1:0]          raddr,
  output wrp_pkg::word_t            rdata
);
  localparam int DEPTH = 1 << IDX_W;

  wrp_pkg::word_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/wrp_id_decode.sv
module wrp_id_decode (
  input  wrp_pkg::waddr_t addr,
  input  logic            a9_hv,
  input  wrp_pkg::word_t  arr_word,
  output wrp_pkg::word_t  word,
  output logic            bad_id
);
  import wrp_pkg::*;

  localparam waddr_t KEEP = waddr_t'(1) | (waddr_t'(1) << HV_BIT);

  logic stray;
  logic id_hit;

  assign stray  = |(addr & ~KEEP);
  assign id_hit = a9_hv && !stray;
  assign bad_id = a9_hv && stray;

  always_comb begin
    if (id_hit) word = {8'h00, (addr[0] ? DEV_CODE : MFR_CODE)};
    else        word = arr_word;
  end
endmodule

// File: rtl/wrp_read_port.sv
module wrp_read_port #(
  parameter int          IDX_W  = 4,
  parameter int unsigned T_ADDR = 10,
  parameter int unsigned T_CE   = 10,
  parameter int unsigned T_OE   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [20:0]      addr,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             a9_hv,
  input  logic             pre_we,
  input  logic [IDX_W-1:0] pre_addr,
  input  logic [15:0]      pre_data,
  output logic [15:0]      dq,
  output logic             dq_oe,
  output logic             id_err
);
  import wrp_pkg::*;

  localparam int NT = 3;
  localparam int unsigned LIM_TAB [NT] = '{T_ADDR, T_CE, T_OE};
  localparam int KW = ADDR_W + 1;

  logic [KW-1:0] key_q;
  logic          key_chg;
  logic [NT-1:0] t_arm, t_kick, t_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= {a9_hv, addr};
  end
  assign key_chg = ({a9_hv, addr} != key_q);

  // timer 0: address settle, 1: chip select, 2: output gate
  assign t_arm  = {!oe_n, !ce_n, 1'b1};
  assign t_kick = {1'b0, 1'b0, key_chg};

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    wrp_settle_timer #(.LIM(LIM_TAB[g])) tmr_i (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (t_arm[g]),
      .kick (t_kick[g]),
      .ok   (t_ok[g])
    );
  end

  word_t arr_word, sel_word;
  logic  bad_id;

  wrp_store #(.IDX_W(IDX_W)) store_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (pre_we),
    .waddr(pre_addr),
    .wdata(pre_data),
    .raddr(addr[IDX_W-1:0]),
    .rdata(arr_word)
  );

  wrp_id_decode dec_i (
    .addr    (addr),
    .a9_hv   (a9_hv),
    .arr_word(arr_word),
    .word    (sel_word),
    .bad_id  (bad_id)
  );

  logic  en_ok;
  logic  drv_q;
  word_t dat_q;
  logic  err_q;

  assign en_ok = t_ok[1] && t_ok[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      dat_q <= '0;
      err_q <= 1'b0;
    end else begin
      drv_q <= en_ok && (t_ok[0] || drv_q);
      if (t_ok[0]) dat_q <= sel_word;
      err_q <= err_q || bad_id;
    end
  end

  assign dq     = drv_q ? dat_q : '0;
  assign dq_oe  = drv_q;
  assign id_err = err_q;
endmodule

// File: rtl/wrp_read_port_chk.sv
module wrp_read_port_chk #(
  parameter int unsigned T_CE = 10,
  parameter int unsigned T_OE = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic [20:0] addr,
  input logic        a9_hv,
  input logic        ce_n,
  input logic        oe_n,
  input logic [15:0] dq,
  input logic        dq_oe,
  input logic        id_err
);
  localparam int CRW = $clog2(T_CE + 2);
  localparam int ORW = $clog2(T_OE + 2);

  logic [CRW-1:0] ce_run;
  logic [ORW-1:0] oe_run;
  logic [21:0]    key_prev;
  logic           key_vld;
  logic           key_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_run   <= '0;
      oe_run   <= '0;
      key_prev <= '0;
      key_vld  <= 1'b0;
    end else begin
      if (ce_n) ce_run <= '0;
      else if (ce_run <= CRW'(T_CE)) ce_run <= ce_run + CRW'(1);
      if (oe_n) oe_run <= '0;
      else if (oe_run <= ORW'(T_OE)) oe_run <= oe_run + ORW'(1);
      key_prev <= {a9_hv, addr};
      key_vld  <= 1'b1;
    end
  end

  assign key_moved = key_vld && ({a9_hv, addr} != key_prev);

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dq_oe); // R2
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |=> !dq_oe); // R3
  AST_RELEASE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> !dq_oe); // R5
  AST_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq == 16'h0000)); // R2
  AST_CE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (ce_run > CRW'(T_CE))); // R4
  AST_OE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (oe_run > ORW'(T_OE))); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !ce_n && !oe_n && key_moved) |=> (dq_oe && $stable(dq))); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |=> id_err); // R10
endmodule

bind wrp_read_port wrp_read_port_chk #(.T_CE(T_CE), .T_OE(T_OE)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .addr  (addr),
  .a9_hv (a9_hv),
  .ce_n  (ce_n),
  .oe_n  (oe_n),
  .dq    (dq),
  .dq_oe (dq_oe),
  .id_err(id_err)
);

// File: tb/wrp_read_port_tb_top.sv
`timescale 1ns/1ps
module wrp_read_port_tb_top;
  localparam int IDX_W  = 4;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int T_ADDR = 10;
  localparam int T_CE   = 10;
  localparam int T_OE   = 5;
  localparam int SETTLE = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [20:0]      addr;
  logic             ce_n, oe_n, a9_hv, pre_we;
  logic [IDX_W-1:0] pre_addr;
  logic [15:0]      pre_data;
  logic [15:0]      dq;
  logic             dq_oe, id_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] model [DEPTH];
  logic        err_model = 1'b0;

  always #5 clk = ~clk;

  wrp_read_port #(.IDX_W(IDX_W), .T_ADDR(T_ADDR), .T_CE(T_CE), .T_OE(T_OE)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .a9_hv(a9_hv),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .dq(dq), .dq_oe(dq_oe), .id_err(id_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [20:0] a, input logic hv, input logic ce, input logic oe);
    @(negedge clk);
    addr = a; a9_hv = hv; ce_n = ce; oe_n = oe;
  endtask

  task automatic load(input int idx, input logic [15:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = IDX_W'(idx); pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
    model[idx] = d;
  endtask

  function automatic logic stray_of(input logic [20:0] a);
    return |(a & ~21'h000201);
  endfunction

  function automatic logic [15:0] exp_word(input logic [20:0] a, input logic hv);
    if (hv && !stray_of(a)) return a[0] ? 16'h0034 : 16'h0020;
    return model[a[IDX_W-1:0]];
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w6;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    rst_n = 1'b0; addr = '0; ce_n = 1'b1; oe_n = 1'b1; a9_hv = 1'b0;
    pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    step(3);
    chk("R1 dq_oe at reset", dq_oe, 0);
    chk("R1 dq at reset", dq, 0);
    chk("R1 id_err at reset", id_err, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: erased contents
    put(21'd0, 0, 0, 0);  step(SETTLE); chk("R1 erased word 0", dq, 16'hFFFF);
    put(21'd5, 0, 0, 0);  step(SETTLE); chk("R1 erased word 5", dq, 16'hFFFF);
    put(21'd15, 0, 0, 0); step(SETTLE); chk("R1 erased word 15", dq, 16'hFFFF);

    // R8: preload every entry
    for (int i = 0; i < DEPTH; i++) load(i, 16'(i * 16'h1357) ^ 16'hA5A5);
    put(21'd3, 0, 0, 0); step(SETTLE);
    chk("R8 preloaded word 3", dq, model[3]);
    // R7: upper bits alias
    put(21'd3 | (21'd1 << 20) | (21'd1 << 9), 0, 0, 0); step(SETTLE);
    chk("R7 aliased read of entry 3", dq, model[3]);

    // R4: chip select delay
    put(21'd6, 0, 1, 0); step(SETTLE);
    chk("R2 standby dq_oe", dq_oe, 0);
    chk("R2 standby dq", dq, 0);
    put(21'd6, 0, 0, 0); step(T_CE);
    chk("R4 ce one edge early", dq_oe, 0);
    step(1);
    chk("R4 ce delay dq_oe", dq_oe, 1);
    chk("R4 ce delay dq", dq, model[6]);
    // R5: release on chip select
    put(21'd6, 0, 1, 0); step(1);
    chk("R5 ce release dq_oe", dq_oe, 0);
    chk("R2 dq zero after release", dq, 0);

    // R3 and R4: output gate
    put(21'd6, 0, 0, 1); step(SETTLE);
    chk("R3 output disable", dq_oe, 0);
    put(21'd6, 0, 0, 0); step(T_OE);
    chk("R4 oe one edge early", dq_oe, 0);
    step(1);
    chk("R4 oe delay dq_oe", dq_oe, 1);
    w6 = model[6];

    // R6: hold old word through an address change
    put(21'd9, 0, 0, 0); step(T_ADDR);
    chk("R6 held dq_oe", dq_oe, 1);
    chk("R6 held old word", dq, w6);
    step(1);
    chk("R6 new word after settle", dq, model[9]);
    // R5: release on output gate
    put(21'd9, 0, 0, 1); step(1);
    chk("R5 oe release dq_oe", dq_oe, 0);

    // R9: identification codes
    put(21'd0, 1, 0, 0); step(SETTLE); chk("R9 maker code", dq, 16'h0020);
    put(21'd1, 1, 0, 0); step(SETTLE); chk("R9 device code", dq, 16'h0034);
    put(21'd1 | (21'd1 << 9), 1, 0, 0); step(SETTLE);
    chk("R9 addr bit 9 ignored", dq, 16'h0034);
    chk("R9 no error on clean id", id_err, 0);

    // R10: stray line falls back to array, sticky error
    put(21'd1 | (21'd1 << 4), 1, 0, 0); step(SETTLE);
    chk("R10 array fallback", dq, model[1]);
    chk("R10 error raised", id_err, 1);
    err_model = 1'b1;
    put(21'd0, 1, 0, 0); step(SETTLE);
    chk("R10 error sticky", id_err, 1);
    chk("R9 code after error", dq, 16'h0020);

    // random mix
    begin
      int unsigned s;
      s = $urandom(32'd20240607);
      for (int it = 0; it < 150; it++) begin
        logic [20:0] a;
        logic hv, ce, oe, eoe;
        int m;
        if ($urandom % 4 == 0) load(int'($urandom % DEPTH), 16'($urandom));
        m = int'($urandom % 4);
        hv = 1'b0;
        a = 21'($urandom);
        if (m == 2) begin
          hv = 1'b1;
          a = (21'($urandom % 2)) | (21'($urandom % 2) << 9);
        end else if (m == 3) begin
          hv = 1'b1;
          a = a | (21'd1 << (1 + ($urandom % 8)));
        end
        ce = ($urandom % 4 == 0);
        oe = ($urandom % 4 == 0);
        put(a, hv, ce, oe);
        step(SETTLE);
        if (hv && stray_of(a)) err_model = 1'b1;
        eoe = !ce && !oe;
        chk("R2/R3 random dq_oe", dq_oe, eoe);
        chk("R7/R9 random dq", dq, eoe ? exp_word(a, hv) : 16'h0000);
        chk("R10 random id_err", id_err, err_model);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule